// File: doc/BRIEF.md
# Replay Output Buffer for Double-Time Redundancy

This block sits on each primary output of a circuit that evaluates every step twice. Its input `co` carries the combinational result as pairs: the first copy arrives on a cycle with `save` low and the second copy on the next cycle with `save` high. The block delays the stream by three cycles. It checks the two copies of each pair against each other and raises `fail` when they differ. It drives three copies of the result, `po_a`, `po_b` and `po_c`, which the logic around it samples on `save`-high cycles and votes two out of three.

The copies come from two separate register chains. A three-stage data chain feeds `po_a` and `po_b`. A two-stage spare chain feeds `po_c`. In normal operation no register drives more than one output, so a flip in any single stage spoils at most one copy. After a mismatch the external controller rolls the circuit back and re-executes three steps at full rate. During that window `subst` is high and the outputs are replaced. On the first recovery sample they take the recomputed value directly from `co`. On the second they take a value held one cycle earlier. The voted stream seen outside is then the same as if no fault had occurred.

Top module: `replay_out_buf`

## Requirements
- R1: An active-low reset clears every stage of both chains. After reset, while `subst` is low, all three outputs read zero and `fail` is low until new data has moved through the stages.
- R2: While `subst` is low, `po_a` equals `co` from two cycles earlier and `po_b` equals `co` from three cycles earlier. With paired input (first copy on a `save`-low cycle, second copy on the next `save`-high cycle), every `save`-high cycle presents on all three outputs the pair whose first copy entered three cycles before.
- R3: `fail` is the OR over all bits of the difference between `co` one cycle earlier and `co` two cycles earlier. On a `save`-low cycle these two samples are the two copies of one pair.
- R4: When `subst` and `save` are both high, all three outputs equal the live `co` of the same cycle.
- R5: When `subst` is high and `save` is low, `po_a` equals `co` from one cycle earlier. `po_b` and `po_c` show the first spare stage, which holds `co` from one cycle earlier if `save` or `rollback` was high in that cycle.
- R6: The first spare stage loads `co` on cycles with `save` or `rollback` high. The second spare stage loads the first on cycles with `save` low. While `subst` is low, `po_c` shows the second spare stage. With alternating `save`, `po_c` therefore equals `co` from two cycles earlier on `save`-high cycles and from three cycles earlier on `save`-low cycles.
- R7: Let a mismatch be detected on cycle i. The controller then drives `save`/`rollback`/`subst` as 1/1/1 on i+1, 0/1/1 on i+2 and i+3, 0/1/0 on i+4, and returns to normal alternation with `save` high on i+5. The input carries the recomputed pair on i+1, the next two pair values once each on i+2 and i+3, and pairs again from i+4. Under these conditions the outputs on the sampled cycles i+1, i+3, i+5 and i+7 give the pair sequence of the fault-free run. All three copies agree on i+1, i+3 and i+7, and at least two are correct on i+5.
- R8: If only the first copy of a pair is corrupted and no recovery follows, then on the sampled cycle that presents that pair only `po_b` carries the wrong value. `po_a` and `po_c` stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| co | input | W | Paired combinational result |
| save | input | 1 | High on second-copy cycles; enables the spare chain |
| rollback | input | 1 | High during recovery; keeps the first spare stage loading |
| subst | input | 1 | Selects substituted outputs during recovery |
| po_a | output | W | Output copy from the data chain, two-cycle tap |
| po_b | output | W | Output copy from the data chain, three-cycle tap |
| po_c | output | W | Output copy from the spare chain |
| fail | output | 1 | Mismatch between consecutive copies |

## Verification
The bound checker tests every cycle against the port history. It checks the two-cycle and three-cycle taps, the form of `fail` as a difference of two past inputs, the live pass-through and held substitution, and the spare chain's load conditions. The checker cannot judge the recovery window as a whole: only the scenarios can show that the voted stream across a rollback matches the fault-free one, that a corrupted input sample is masked, and that a corrupted first copy leaves only `po_b` wrong. The scenarios sweep single-bit corruptions over every bit position and both copies of a pair, and include a recovery forced with no corruption.

// File: rtl/replay_out_buf.sv
module replay_out_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] co,
  input  logic         save,
  input  logic         rollback,
  input  logic         subst,
  output logic [W-1:0] po_a,
  output logic [W-1:0] po_b,
  output logic [W-1:0] po_c,
  output logic         fail
);

  logic [W-1:0] d0, d1, d2;
  logic [W-1:0] s0, s1;
  logic         live, held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d0 <= '0;
      d1 <= '0;
      d2 <= '0;
    end else begin
      d0 <= co;
      d1 <= d0;
      d2 <= d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= '0;
      s1 <= '0;
    end else begin
      if (save || rollback) s0 <= co;
      if (!save)            s1 <= s0;
    end
  end

  assign live = subst & save;
  assign held = subst & ~save;

  assign po_a = live ? co : (held ? d0 : d1);
  assign po_b = live ? co : (held ? s0 : d2);
  assign po_c = live ? co : (held ? s0 : s1);

  assign fail = |(d0 ^ d1);

endmodule

// File: rtl/replay_out_buf_chk.sv
module replay_out_buf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] co,
  input logic         save,
  input logic         rollback,
  input logic         subst,
  input logic [W-1:0] po_a,
  input logic [W-1:0] po_b,
  input logic [W-1:0] po_c,
  input logic         fail
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0 && !subst) |-> (po_a == '0 && po_b == '0 && po_c == '0 && !fail));

  a_r2_tap_two: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !subst) |-> (po_a == $past(co, 2)));

  a_r2_tap_three: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !subst) |-> (po_b == $past(co, 3)));

  a_r3_pair_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (fail == (|($past(co, 1) ^ $past(co, 2)))));

  a_r4_live_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (subst && save) |-> (po_a == co && po_b == co && po_c == co));

  a_r5_held_a: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && subst && !save) |-> (po_a == $past(co)));

  a_r5_held_spare: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && subst && !save && $past(save || rollback)) |->
    (po_b == $past(co) && po_c == $past(co)));

  a_r6_spare_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !subst && !$past(save) && $past(save || rollback, 2)) |->
    (po_c == $past(co, 2)));

endmodule

bind replay_out_buf replay_out_buf_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .co(co), .save(save), .rollback(rollback),
  .subst(subst), .po_a(po_a), .po_b(po_b), .po_c(po_c), .fail(fail)
);

// File: tb/replay_out_buf_test.sv
`timescale 1ns/1ps
module replay_out_buf_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] co = '0;
  logic         save = 1'b0, rollback = 1'b0, subst = 1'b0;
  logic [W-1:0] po_a, po_b, po_c;
  logic         fail;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] ra, rb, rc;
  logic         rf;
  logic [W-1:0] cur = '0, h0 = '0, h1 = '0, h2 = '0;
  logic [W-1:0] prev;

  always #4 clk = ~clk;

  replay_out_buf #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .co(co), .save(save), .rollback(rollback),
    .subst(subst), .po_a(po_a), .po_b(po_b), .po_c(po_c), .fail(fail)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [W-1:0] c, input logic s, input logic r, input logic u);
    @(negedge clk);
    h2 = h1; h1 = h0; h0 = cur; cur = c;
    co = c; save = s; rollback = r; subst = u;
    #1;
    ra = po_a; rb = po_b; rc = po_c; rf = fail;
  endtask

  task automatic pair(input logic [W-1:0] v, input logic [W-1:0] pv, input bit look);
    tick(v, 1'b0, 1'b0, 1'b0);
    if (look) check(rf == 1'b0, "R3 fail low on matching copies", W'(rf), '0);
    tick(v, 1'b1, 1'b0, 1'b0);
    if (look) begin
      check(ra == pv, "R2 po_a on sampled cycle", ra, pv);
      check(rb == pv, "R2 po_b on sampled cycle", rb, pv);
      check(rc == pv, "R2 po_c on sampled cycle", rc, pv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(po_a == '0 && po_b == '0 && po_c == '0, "R1 outputs zero in reset", po_a, '0);
    check(fail == 1'b0, "R1 fail low in reset", W'(fail), '0);
    @(negedge clk);
    rst_n = 1'b1;

    tick(W'(9), 1'b0, 1'b0, 1'b0);
    check(ra == '0 && rb == '0 && rc == '0, "R1 outputs zero after reset", ra, '0);
    check(rf == 1'b0, "R1 fail low after reset", W'(rf), '0);
    tick(W'(9), 1'b1, 1'b0, 1'b0);
    check(ra == '0 && rb == '0 && rc == '0, "R1 outputs zero before data", rb, '0);
    prev = W'(9);

    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] v;
      v = W'(k * 7 + 3);
      pair(v, prev, 1'b1);
      prev = v;
    end

    for (int n = 0; n < 48; n++) begin
      logic s;
      s = n[0];
      tick(W'(n * 5 + 1), s, 1'b0, 1'b0);
      check(ra == h1, "R2 po_a two-cycle tap", ra, h1);
      check(rb == h2, "R2 po_b three-cycle tap", rb, h2);
      check(rc == (s ? h1 : h2), "R6 spare chain on po_c", rc, s ? h1 : h2);
      check(rf == (|(h0 ^ h1)), "R3 fail equals copy mismatch", W'(rf), W'(|(h0 ^ h1)));
    end

    pair(W'(5), W'(0), 1'b0);
    pair(W'(5), W'(0), 1'b0);
    prev = W'(5);

    for (int b = 0; b < W; b++) begin
      logic [W-1:0] v, w, g;
      v = W'(b * 3 + 2);
      w = W'(b * 3 + 7);
      g = v ^ W'(1 << b);
      tick(g, 1'b0, 1'b0, 1'b0);
      tick(v, 1'b1, 1'b0, 1'b0);
      check(ra == prev && rb == prev && rc == prev, "R2 outputs before corrupted pair", rb, prev);
      tick(w, 1'b0, 1'b0, 1'b0);
      check(rf == 1'b1, "R3 first-copy corruption detected", W'(rf), W'(1));
      tick(w, 1'b1, 1'b0, 1'b0);
      check(ra == v, "R8 po_a unaffected", ra, v);
      check(rc == v, "R8 po_c unaffected", rc, v);
      check(rb == g, "R8 only po_b carries corruption", rb, g);
      prev = w;
      pair(W'(b + 11), prev, 1'b1);
      prev = W'(b + 11);
    end

    for (int b = 0; b <= W; b++) begin
      for (int side = 0; side < 2; side++) begin
        logic [W-1:0] vm, v1, v2, v3, v4, msk;
        int agree;
        if (b == W && side == 1) continue;
        vm = W'(b * 5 + side + 1);
        v1 = vm + W'(1);
        v2 = vm + W'(6);
        v3 = vm + W'(11);
        v4 = vm + W'(3);
        msk = (b < W) ? W'(1 << b) : '0;
        tick(side == 0 ? (vm ^ msk) : vm, 1'b0, 1'b0, 1'b0);
        tick(side == 1 ? (vm ^ msk) : vm, 1'b1, 1'b0, 1'b0);
        check(ra == prev && rb == prev && rc == prev, "R7 outputs before detection", ra, prev);
        tick(~v1, 1'b0, 1'b0, 1'b0);
        check(rf == (b < W), "R3 detection on corrupted pair", W'(rf), W'(b < W));
        tick(vm, 1'b1, 1'b1, 1'b1);
        check(ra == vm && rb == vm && rc == vm, "R4 R7 live substitution at i+1", rb, vm);
        tick(v1, 1'b0, 1'b1, 1'b1);
        tick(v2, 1'b0, 1'b1, 1'b1);
        check(ra == v1 && rb == v1 && rc == v1, "R5 R7 held substitution at i+3", rc, v1);
        tick(v3, 1'b0, 1'b1, 1'b0);
        tick(v3, 1'b1, 1'b0, 1'b0);
        agree = int'(ra == v2) + int'(rb == v2) + int'(rc == v2);
        check(agree >= 2, "R7 two of three correct at i+5", ra, v2);
        check(ra == v2 && rc == v2, "R7 po_a and po_c at i+5", rc, v2);
        tick(v4, 1'b0, 1'b0, 1'b0);
        check(rf == 1'b0, "R3 fail low after recovery", W'(rf), '0);
        tick(v4, 1'b1, 1'b0, 1'b0);
        check(ra == v3 && rb == v3 && rc == v3, "R7 all agree at i+7", rb, v3);
        prev = v4;
        pair(vm + W'(9), prev, 1'b1);
        prev = vm + W'(9);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-R8 run actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule